// File: doc/BRIEF.md
# Frequency Readout Text Sequencer

This block turns a binary frequency count into one fixed-length line of text on a character display. The line has three parts: the label `DET. FREQ= `, six decimal digits with leading zeros kept, and the unit ` Hz`. The six digits come from a shift-and-add-3 converter. A 3-bit index picks one digit at a time, and the picked digit is sent to the display as ASCII. The characters go out through a plain display write port. That port has a register-select line (0 means command, 1 means character), an 8-bit data bus and an enable strobe of fixed width.

After reset the block sends a short initialisation sequence to the display, once only. It then writes the line over and over. Each line begins with a cursor-home command. The input value is captured only at the moment a new line begins, so the six digits of a line always come from one sample.

The sequencer has five states. `ST_INIT` sends the four set-up commands and moves to `ST_HOME` after the last one. `ST_HOME` sends cursor-home and moves to `ST_LABEL`. `ST_LABEL` sends the 11 label characters and then moves to `ST_DIGIT`. `ST_DIGIT` sends the digits from index 5 down to index 0 and then moves to `ST_UNIT`. `ST_UNIT` sends the 3 unit characters and returns to `ST_HOME`. Every move into `ST_HOME` captures a new sample. The write engine has three states. `W_IDLE` accepts the current character and moves to `W_STROBE`. `W_STROBE` holds enable high and moves to `W_GAP`. `W_GAP` holds enable low, returns to `W_IDLE` and signals completion, and that completion advances the sequencer.

Top module: `frt_readout`

## Requirements
- R1: While reset is asserted, lcd_en, lcd_rs and lcd_data are all zero.
- R2: The first four writes after reset are commands (lcd_rs = 0) carrying 0x38, 0x0C, 0x01 and 0x06, in that order.
- R3: Every line starts with the command 0x80 (lcd_rs = 0).
- R4: After the home command come 11 character writes (lcd_rs = 1) spelling `DET. FREQ= `.
- R5: After the label come six character writes, most significant digit first. Each one is 0x30 plus the decimal digit, and leading zeros are printed as 0x30.
- R6: The line ends with three character writes spelling ` Hz` (0x20, 0x48, 0x7A).
- R7: For inputs from 0 to 999999, the six digits are the exact decimal value of the input.
- R8: An input above 999999 is shown as 999999.
- R9: lcd_en stays high for exactly 8 consecutive clock cycles on each write, and lcd_rs and lcd_data do not change while it is high.
- R10: Between two writes, lcd_en stays low for exactly 65 clock cycles: a 64-cycle gap plus one accept cycle.
- R11: The input is captured only when a line begins. Changes to freq_bin while a line is being written do not affect the digits of that line.
- R12: Lines repeat without end, and the initialisation commands are never sent again after the first line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_bin | input | 20 | Binary frequency value; captured at the start of each line |
| lcd_rs | output | 1 | Register select: 0 for a command, 1 for a character |
| lcd_data | output | 8 | Command or ASCII character byte |
| lcd_en | output | 1 | Write strobe, 8 cycles wide |

## Verification
The assertions place no constraint on freq_bin. It may change on any cycle and take any 20-bit value. The assertions rely only on rst_n being released synchronously. The stimulus applies each table value before its line begins. It then overwrites freq_bin with a scrambled value while the line is being written, to show that the capture point holds. The stimulus also includes two values above the six-digit range, which exercise the clamp.

// File: rtl/frt_pkg.sv
package frt_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_HOME,
        ST_LABEL,
        ST_DIGIT,
        ST_UNIT
    } seq_state_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_STROBE,
        W_GAP
    } wr_state_t;

    localparam int INIT_LEN  = 4;
    localparam int LABEL_LEN = 11;
    localparam int UNIT_LEN  = 3;
    localparam logic [7:0] CMD_HOME = 8'h80;

    // display set-up commands, issued once after reset
    function automatic logic [7:0] init_cmd(input logic [3:0] idx);
        unique case (idx)
            4'd0:    return 8'h38;
            4'd1:    return 8'h0C;
            4'd2:    return 8'h01;
            default: return 8'h06;
        endcase
    endfunction

    // text "DET. FREQ= "
    function automatic logic [7:0] label_char(input logic [3:0] idx);
        unique case (idx)
            4'd0:    return 8'h44;
            4'd1:    return 8'h45;
            4'd2:    return 8'h54;
            4'd3:    return 8'h2E;
            4'd4:    return 8'h20;
            4'd5:    return 8'h46;
            4'd6:    return 8'h52;
            4'd7:    return 8'h45;
            4'd8:    return 8'h51;
            4'd9:    return 8'h3D;
            default: return 8'h20;
        endcase
    endfunction

    // text " Hz"
    function automatic logic [7:0] unit_char(input logic [3:0] idx);
        unique case (idx)
            4'd0:    return 8'h20;
            4'd1:    return 8'h48;
            default: return 8'h7A;
        endcase
    endfunction

endpackage

// File: rtl/frt_bin2bcd.sv
module frt_bin2bcd #(
    parameter int BIN_W  = 20,
    parameter int DIGITS = 6
) (
    input  logic [BIN_W-1:0]    bin,
    output logic [DIGITS*4-1:0] bcd
);

    localparam int BCD_W = DIGITS * 4;

    logic [BCD_W-1:0] acc;

    // shift-and-add-3: adjust every nibble of 5 or more, then shift in one bit
    always_comb begin
        acc = '0;
        for (int i = BIN_W - 1; i >= 0; i--) begin
            for (int d = 0; d < DIGITS; d++) begin
                if (acc[d*4 +: 4] >= 4'd5) begin
                    acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
                end
            end
            acc = {acc[BCD_W-2:0], bin[i]};
        end
        bcd = acc;
    end

endmodule

// File: rtl/frt_digit_ascii.sv
module frt_digit_ascii #(
    parameter int DIGITS = 6,
    parameter int SEL_W  = 3
) (
    input  logic [DIGITS*4-1:0] bcd,
    input  logic [SEL_W-1:0]    sel,
    output logic [7:0]          ascii
);

    always_comb begin
        ascii = 8'h3F;
        for (int d = 0; d < DIGITS; d++) begin
            if (sel == SEL_W'(d)) begin
                ascii = 8'h30 + {4'h0, bcd[d*4 +: 4]};
            end
        end
    end

endmodule

// File: rtl/frt_writer.sv
module frt_writer
    import frt_pkg::*;
#(
    parameter int EN_CYCLES  = 8,
    parameter int GAP_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       char_rs,
    input  logic [7:0] char_data,
    output logic       done,
    output logic       lcd_rs,
    output logic [7:0] lcd_data,
    output logic       lcd_en
);

    localparam int CNT_MAX = (EN_CYCLES > GAP_CYCLES) ? EN_CYCLES : GAP_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    wr_state_t        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             rs_q;
    logic [7:0]       data_q;

    always_comb begin
        nxt  = state;
        done = 1'b0;
        unique case (state)
            W_IDLE:   nxt = W_STROBE;
            W_STROBE: if (cnt == CNT_W'(EN_CYCLES - 1)) nxt = W_GAP;
            W_GAP: begin
                if (cnt == CNT_W'(GAP_CYCLES - 1)) begin
                    nxt  = W_IDLE;
                    done = 1'b1;
                end
            end
            default:  nxt = W_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
        end
    end

    // output register: latch the character offered while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q   <= 1'b0;
            data_q <= 8'h00;
        end else if (state == W_IDLE) begin
            rs_q   <= char_rs;
            data_q <= char_data;
        end
    end

    assign lcd_en   = (state == W_STROBE);
    assign lcd_rs   = rs_q;
    assign lcd_data = data_q;

    p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_en) |=> lcd_en);

    p_bus_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && $past(lcd_en)) |-> ($stable(lcd_data) && $stable(lcd_rs)));

    p_gap_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_en) |=> !lcd_en);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !lcd_en);

endmodule

// File: rtl/frt_readout.sv
module frt_readout
    import frt_pkg::*;
#(
    parameter int BIN_W      = 20,
    parameter int DIGITS     = 6,
    parameter int EN_CYCLES  = 8,
    parameter int GAP_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BIN_W-1:0] freq_bin,
    output logic             lcd_rs,
    output logic [7:0]       lcd_data,
    output logic             lcd_en
);

    localparam int IDX_W = 4;
    localparam int SEL_W = $clog2(DIGITS);
    localparam logic [BIN_W-1:0] MAX_VAL = BIN_W'(10 ** DIGITS - 1);

    seq_state_t             state, nxt;
    logic [IDX_W-1:0]       idx, idx_nxt;
    logic [BIN_W-1:0]       freq_q;
    logic [BIN_W-1:0]       freq_clamped;
    logic                   load_freq;
    logic                   wr_done;
    logic [DIGITS*4-1:0]    bcd;
    logic [7:0]             digit_char;
    logic                   char_rs;
    logic [7:0]             char_data;

    assign freq_clamped = (freq_bin > MAX_VAL) ? MAX_VAL : freq_bin;

    frt_bin2bcd #(.BIN_W(BIN_W), .DIGITS(DIGITS)) u_b2b (
        .bin (freq_q),
        .bcd (bcd)
    );

    frt_digit_ascii #(.DIGITS(DIGITS), .SEL_W(SEL_W)) u_dsel (
        .bcd   (bcd),
        .sel   (idx[SEL_W-1:0]),
        .ascii (digit_char)
    );

    frt_writer #(.EN_CYCLES(EN_CYCLES), .GAP_CYCLES(GAP_CYCLES)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_rs   (char_rs),
        .char_data (char_data),
        .done      (wr_done),
        .lcd_rs    (lcd_rs),
        .lcd_data  (lcd_data),
        .lcd_en    (lcd_en)
    );

    // next state: advance one character per completed write
    always_comb begin
        nxt       = state;
        idx_nxt   = idx;
        load_freq = 1'b0;
        if (wr_done) begin
            unique case (state)
                ST_INIT: begin
                    if (idx == IDX_W'(INIT_LEN - 1)) begin
                        nxt       = ST_HOME;
                        idx_nxt   = '0;
                        load_freq = 1'b1;
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
                ST_HOME: begin
                    nxt     = ST_LABEL;
                    idx_nxt = '0;
                end
                ST_LABEL: begin
                    if (idx == IDX_W'(LABEL_LEN - 1)) begin
                        nxt     = ST_DIGIT;
                        idx_nxt = IDX_W'(DIGITS - 1);
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
                ST_DIGIT: begin
                    if (idx == '0) begin
                        nxt     = ST_UNIT;
                        idx_nxt = '0;
                    end else begin
                        idx_nxt = idx - 1'b1;
                    end
                end
                ST_UNIT: begin
                    if (idx == IDX_W'(UNIT_LEN - 1)) begin
                        nxt       = ST_HOME;
                        idx_nxt   = '0;
                        load_freq = 1'b1;
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
                default: begin
                    nxt     = ST_INIT;
                    idx_nxt = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_INIT;
            idx    <= '0;
            freq_q <= '0;
        end else begin
            state <= nxt;
            idx   <= idx_nxt;
            if (load_freq) freq_q <= freq_clamped;
        end
    end

    // character offered to the writer
    always_comb begin
        unique case (state)
            ST_INIT:  begin char_rs = 1'b0; char_data = init_cmd(idx);   end
            ST_HOME:  begin char_rs = 1'b0; char_data = CMD_HOME;        end
            ST_LABEL: begin char_rs = 1'b1; char_data = label_char(idx); end
            ST_DIGIT: begin char_rs = 1'b1; char_data = digit_char;      end
            ST_UNIT:  begin char_rs = 1'b1; char_data = unit_char(idx);  end
            default:  begin char_rs = 1'b0; char_data = 8'h00;           end
        endcase
    end

    p_init_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT && lcd_en) |-> !lcd_rs);

    p_digit_ascii_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIGIT && lcd_en) |-> (lcd_rs && lcd_data >= 8'h30 && lcd_data <= 8'h39));

    p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freq_q <= MAX_VAL);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LABEL || state == ST_DIGIT) |=> $stable(freq_q));

    p_no_reinit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_INIT) |=> (state != ST_INIT));

    for (genvar g = 0; g < DIGITS; g++) begin : g_bcd_chk
        p_bcd_digit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            bcd[g*4 +: 4] <= 4'd9);
    end

endmodule

// File: tb/frt_readout_tb.sv
module frt_readout_tb;

    localparam int NVEC = 9;
    localparam int VEC_IN  [NVEC] = '{83300, 0, 999999, 123456, 7, 1000000, 1048575, 500005, 90909};
    localparam int VEC_EXP [NVEC] = '{83300, 0, 999999, 123456, 7, 999999, 999999, 500005, 90909};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] freq_bin = 20'd0;
    logic        lcd_rs;
    logic [7:0]  lcd_data;
    logic        lcd_en;

    int checks = 0;
    int errors = 0;
    bit first_write = 1'b1;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    frt_readout u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_bin (freq_bin),
        .lcd_rs   (lcd_rs),
        .lcd_data (lcd_data),
        .lcd_en   (lcd_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // capture one write; checks strobe width (R9) and preceding gap (R10)
    task automatic get_write(output logic rs, output logic [7:0] d);
        int low = 1;
        int high = 0;
        @(negedge clk);
        while (!lcd_en) begin
            low++;
            @(negedge clk);
        end
        rs = lcd_rs;
        d  = lcd_data;
        while (lcd_en) begin
            high++;
            chk(lcd_rs == rs && lcd_data == d, "R9 bus stable", int'(lcd_data), int'(d));
            @(negedge clk);
        end
        chk(high == 8, "R9 enable width", high, 8);
        if (!first_write) chk(low == 65, "R10 low gap", low, 65);
        first_write = 1'b0;
    endtask

    task automatic check_line(input int k);
        string lbl = "DET. FREQ= ";
        string unt = " Hz";
        logic rs;
        logic [7:0] d;
        int p10;
        get_write(rs, d);
        chk(rs == 1'b0 && d == 8'h80, "R3 R12 home command", int'(d), 8'h80);
        freq_bin = ~20'(VEC_IN[k]);  // R11: mid-line change must not show
        for (int i = 0; i < 11; i++) begin
            get_write(rs, d);
            chk(rs == 1'b1 && d == lbl[i], "R4 label char", int'(d), int'(lbl[i]));
        end
        p10 = 100000;
        for (int i = 0; i < 6; i++) begin
            int exp_c = 8'h30 + (VEC_EXP[k] / p10) % 10;
            get_write(rs, d);
            if (VEC_IN[k] > 999999)
                chk(rs == 1'b1 && d == 8'(exp_c), "R8 clamped digit", int'(d), exp_c);
            else
                chk(rs == 1'b1 && d == 8'(exp_c), "R5 R7 R11 digit", int'(d), exp_c);
            p10 = p10 / 10;
        end
        for (int i = 0; i < 3; i++) begin
            get_write(rs, d);
            chk(rs == 1'b1 && d == unt[i], "R6 unit char", int'(d), int'(unt[i]));
        end
    endtask

    initial begin
        logic rs;
        logic [7:0] d;
        logic [7:0] init_exp [4] = '{8'h38, 8'h0C, 8'h01, 8'h06};
        freq_bin = 20'(VEC_IN[0]);
        repeat (4) @(negedge clk);
        chk(lcd_en == 1'b0, "R1 reset enable", int'(lcd_en), 0);
        chk(lcd_rs == 1'b0, "R1 reset rs", int'(lcd_rs), 0);
        chk(lcd_data == 8'h00, "R1 reset data", int'(lcd_data), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            get_write(rs, d);
            chk(rs == 1'b0 && d == init_exp[i], "R2 init command", int'(d), int'(init_exp[i]));
        end
        // vector table walk
        for (int k = 0; k < NVEC; k++) begin
            check_line(k);
            freq_bin = 20'(VEC_IN[(k + 1) % NVEC]);
        end
        // R12: one more line after the table, no re-initialisation
        check_line(0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule